// File: doc/BRIEF.md
# Multiplexed-Bus Register and RAM Map

This block is the host side of a small byte-wide memory map. A host shares eight lines for address and data. It first presents an address, which the block captures when the address strobe falls. It then moves one byte in a data phase. Chip select is sampled only at the moment the address is captured. A cycle that begins without it neither writes anything nor drives the lines. A strapping input picks one of two strobe styles. In the direction-level style, one pin is a data strobe and the other gives the transfer direction. In the split style, the same two pins are separate active-low read and write strobes.

The 128-location main map starts with fourteen clock/control bytes and holds general-purpose RAM in the remaining 114 locations. When the top address bit is high, the access goes to a separate 64-byte RAM bank instead. A timekeeping engine inside the chip updates the clock bytes through a valid/ready stream. The host reads those bytes from a holding copy that stays frozen while an update burst is in flight, so it never sees a half-applied update. An active-low clear input fills every RAM byte in both RAM areas with ones and leaves the clock bytes alone.

All bus pins are sampled on the system clock, and the external bus is assumed to be slow compared with that clock.

Top module: `mbus_regfile`

## Requirements
- R1: The address byte on `ad_i` and the select state (`cs_n` low) are captured when `as_i` falls. A cycle captured with `cs_n` high performs no write and never raises `ad_oe`.
- R2: With `bus_mode` = 1 (direction-level style), a selected cycle drives data while `ds_rd_i` = 1 and `rw_wr_i` = 1. A write commits the byte on `ad_i` when `ds_rd_i` falls while `rw_wr_i` = 0.
- R3: With `bus_mode` = 0 (split style), a selected cycle drives data while `ds_rd_i` (read strobe) is low. A write commits the byte on `ad_i` when `rw_wr_i` (write strobe) rises.
- R4: `ad_oe` is low outside the read phase of a selected cycle. `ad_o` reads 0 whenever `ad_oe` is low.
- R5: With address bit 7 = 0, locations 0 to 13 are clock/control bytes and locations 14 to 127 are RAM. Every location holds the last byte written to it.
- R6: With address bit 7 = 1, bits 5:0 select one of 64 bank bytes. These bytes are separate from every main-map location.
- R7: While `ram_clr_n` is low, all 114 main RAM bytes and all 64 bank bytes become 0xFF, and host writes to RAM are ignored. Clock/control bytes keep their values.
- R8: Reset clears every clock/control byte to 0 and leaves `ad_oe` low.
- R9: A timekeeper beat is taken when `tk_valid` and `tk_ready` are both high. It writes `tk_data` into clock byte `tk_idx`. `tk_ready` drops only for the single cycle in which a host write to a clock byte commits.
- R10: Host reads of clock bytes come from a holding copy. This copy keeps its pre-burst values from the first accepted beat until the beat with `tk_last` = 1, and it shows the new values one cycle after that last beat.
- R11: A host write to a clock byte updates both the live and held values, so the next host read returns the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode | input | 1 | 1 = data strobe plus direction level, 0 = split read/write strobes |
| cs_n | input | 1 | Active-low chip select, sampled at address capture |
| as_i | input | 1 | Address strobe; address is captured on its falling edge |
| ds_rd_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_wr_i | input | 1 | Read-high/write-low level (mode 1) or active-low write strobe (mode 0) |
| ad_i | input | 8 | Address/data lines, input side |
| ad_o | output | 8 | Read data, output side |
| ad_oe | output | 1 | Output enable for the shared lines |
| ram_clr_n | input | 1 | Active-low fill-with-ones for the RAM areas |
| tk_valid | input | 1 | Timekeeper beat valid |
| tk_ready | output | 1 | Timekeeper beat ready |
| tk_last | input | 1 | Marks the final beat of an update burst |
| tk_idx | input | 4 | Clock byte index of the beat |
| tk_data | input | 8 | Byte carried by the beat |

## Verification
Every bus pin passes through one register stage, and edges are found by comparing that stage with the next. The address and select are therefore captured two rising edges after `as_i` falls. A write commits two edges after its strobe releases. `ad_oe` and `ad_o` follow the read strobe with a one-edge delay, and the holding copy shows new clock values one edge after the last timekeeper beat. The bench drives on falling edges and waits at least two full cycles after each strobe change before it samples or moves on. This sampling point sits beyond every one of those delays. It also tracks `tk_ready` on every falling edge, to confirm that the yield lasts exactly one cycle per clock-byte write.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    STYLE_SPLIT    = 1'b0,
    STYLE_DIRLEVEL = 1'b1
  } strobe_style_e;

  typedef struct packed {
    logic  sel;
    byte_t addr;
  } cycle_t;
endpackage

// File: rtl/mbus_front.sv
module mbus_front
  import mbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_style_e style,
  input  logic          cs_n,
  input  logic          as_i,
  input  logic          strb_a,
  input  logic          strb_b,
  input  byte_t         ad_i,
  output cycle_t        cyc,
  output logic          rd_act,
  output logic          wr_fire,
  output byte_t         wdata
);
  logic  as_s, as_d, a_s, a_d, b_s, b_d, cs_s;
  byte_t ad_s;
  logic  rd_phase, wr_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_s <= 1'b0;
      as_d <= 1'b0;
      a_s  <= 1'b0;
      a_d  <= 1'b0;
      b_s  <= 1'b1;
      b_d  <= 1'b1;
      cs_s <= 1'b1;
      ad_s <= '0;
      cyc  <= '0;
    end else begin
      as_s <= as_i;
      as_d <= as_s;
      a_s  <= strb_a;
      a_d  <= a_s;
      b_s  <= strb_b;
      b_d  <= b_s;
      cs_s <= cs_n;
      ad_s <= ad_i;
      if (as_d && !as_s) begin
        cyc.sel  <= ~cs_s;
        cyc.addr <= ad_s;
      end
    end
  end

  always_comb begin
    if (style == STYLE_DIRLEVEL) begin
      rd_phase = a_s & b_s;
      wr_edge  = a_d & ~a_s & ~b_s;
    end else begin
      rd_phase = ~a_s;
      wr_edge  = ~b_d & b_s;
    end
  end

  assign rd_act  = cyc.sel & rd_phase;
  assign wr_fire = cyc.sel & wr_edge;
  assign wdata   = ad_s;
endmodule

// File: rtl/mbus_ctrl_regs.sv
module mbus_ctrl_regs
  import mbus_pkg::*;
#(
  parameter int unsigned N_REGS = 14,
  parameter int unsigned IDX_W  = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  byte_t            host_data,
  input  logic             tk_valid,
  output logic             tk_ready,
  input  logic             tk_last,
  input  logic [IDX_W-1:0] tk_idx,
  input  byte_t            tk_data,
  input  logic [IDX_W-1:0] rd_idx,
  output byte_t            rd_data
);
  byte_t live [N_REGS];
  byte_t hold [N_REGS];
  logic  busy;
  logic  tk_acc;

  assign tk_ready = ~host_we;
  assign tk_acc   = tk_valid & tk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (tk_acc) busy <= ~tk_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REGS; i++) begin
        live[i] <= '0;
        hold[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_REGS; i++) begin
        if (host_we && host_idx == IDX_W'(i)) begin
          live[i] <= host_data;
          hold[i] <= host_data;
        end else begin
          if (tk_acc && tk_idx == IDX_W'(i)) live[i] <= tk_data;
          if (!busy) hold[i] <= live[i];
        end
      end
    end
  end

  assign rd_data = (32'(rd_idx) < N_REGS) ? hold[rd_idx] : '0;
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram
  import mbus_pkg::*;
#(
  parameter int unsigned MAIN_N = 114,
  parameter int unsigned BANK_N = 64,
  parameter int unsigned MI_W   = 7,
  parameter int unsigned BI_W   = $clog2(BANK_N)
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic            we,
  input  logic            bank,
  input  logic [MI_W-1:0] midx,
  input  logic [BI_W-1:0] bidx,
  input  byte_t           wdata,
  output byte_t           rdata
);
  byte_t main_mem [MAIN_N];
  byte_t bank_mem [BANK_N];

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      for (int i = 0; i < MAIN_N; i++) main_mem[i] <= '1;
      for (int j = 0; j < BANK_N; j++) bank_mem[j] <= '1;
    end else if (we) begin
      if (bank) bank_mem[bidx] <= wdata;
      else if (32'(midx) < MAIN_N) main_mem[midx] <= wdata;
    end
  end

  always_comb begin
    if (bank) rdata = bank_mem[bidx];
    else if (32'(midx) < MAIN_N) rdata = main_mem[midx];
    else rdata = '1;
  end
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
  import mbus_pkg::*;
#(
  parameter int unsigned MAP_SIZE  = 128,
  parameter int unsigned CTRL_REGS = 14,
  parameter int unsigned BANK_SIZE = 64,
  parameter int unsigned BANK_BIT  = 7,
  localparam int unsigned CW = $clog2(CTRL_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          cs_n,
  input  logic          as_i,
  input  logic          ds_rd_i,
  input  logic          rw_wr_i,
  input  logic [7:0]    ad_i,
  output logic [7:0]    ad_o,
  output logic          ad_oe,
  input  logic          ram_clr_n,
  input  logic          tk_valid,
  output logic          tk_ready,
  input  logic          tk_last,
  input  logic [CW-1:0] tk_idx,
  input  logic [7:0]    tk_data
);
  localparam int unsigned AW     = $clog2(MAP_SIZE);
  localparam int unsigned MAIN_N = MAP_SIZE - CTRL_REGS;
  localparam int unsigned BI_W   = $clog2(BANK_SIZE);

  cycle_t        cyc;
  logic          rd_act, wr_fire;
  byte_t         wdata, ctrl_rd, ram_rd;
  logic          in_bank, is_ctrl;
  logic [AW-1:0] map_a, midx;
  logic [BI_W-1:0] bidx;
  strobe_style_e style;

  assign style = strobe_style_e'(bus_mode);

  mbus_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .style   (style),
    .cs_n    (cs_n),
    .as_i    (as_i),
    .strb_a  (ds_rd_i),
    .strb_b  (rw_wr_i),
    .ad_i    (ad_i),
    .cyc     (cyc),
    .rd_act  (rd_act),
    .wr_fire (wr_fire),
    .wdata   (wdata)
  );

  assign in_bank = cyc.addr[BANK_BIT];
  assign map_a   = cyc.addr[AW-1:0];
  assign is_ctrl = ~in_bank & (32'(map_a) < CTRL_REGS);
  assign midx    = map_a - AW'(CTRL_REGS);
  assign bidx    = cyc.addr[BI_W-1:0];

  mbus_ctrl_regs #(.N_REGS(CTRL_REGS), .IDX_W(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (wr_fire & is_ctrl),
    .host_idx  (map_a[CW-1:0]),
    .host_data (wdata),
    .tk_valid  (tk_valid),
    .tk_ready  (tk_ready),
    .tk_last   (tk_last),
    .tk_idx    (tk_idx),
    .tk_data   (tk_data),
    .rd_idx    (map_a[CW-1:0]),
    .rd_data   (ctrl_rd)
  );

  mbus_ram #(.MAIN_N(MAIN_N), .BANK_N(BANK_SIZE), .MI_W(AW), .BI_W(BI_W)) u_ram (
    .clk   (clk),
    .clr_n (ram_clr_n),
    .we    (wr_fire & ~is_ctrl),
    .bank  (in_bank),
    .midx  (midx),
    .bidx  (bidx),
    .wdata (wdata),
    .rdata (ram_rd)
  );

  assign ad_oe = rd_act;
  assign ad_o  = rd_act ? (is_ctrl ? ctrl_rd : ram_rd) : '0;
endmodule

// File: rtl/mbus_regfile_chk.sv
module mbus_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_mode,
  input logic       ds_rd_i,
  input logic       rw_wr_i,
  input logic       ad_oe,
  input logic [7:0] ad_o,
  input logic       ram_clr_n,
  input logic       tk_ready,
  input logic       sel,
  input logic       host_wr,
  input logic       ctrl_hit
);
  p_drive_needs_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> sel);

  p_dir_read_levels_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && ad_oe) |-> ($past(ds_rd_i) && $past(rw_wr_i)));

  p_split_read_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_mode && ad_oe) |-> !$past(ds_rd_i));

  p_clear_reads_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_clr_n && $past(!ram_clr_n) && ad_oe && !ctrl_hit) |-> (ad_o == 8'hFF));

  p_reset_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> !ad_oe);

  p_ready_yields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tk_ready |-> (host_wr && ctrl_hit));
endmodule

bind mbus_regfile mbus_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_mode  (bus_mode),
  .ds_rd_i   (ds_rd_i),
  .rw_wr_i   (rw_wr_i),
  .ad_oe     (ad_oe),
  .ad_o      (ad_o),
  .ram_clr_n (ram_clr_n),
  .tk_ready  (tk_ready),
  .sel       (cyc.sel),
  .host_wr   (wr_fire),
  .ctrl_hit  (is_ctrl)
);

// File: tb/mbus_regfile_bench.sv
module mbus_regfile_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_mode = 1'b1;
  logic       cs_n = 1'b1;
  logic       as_i = 1'b0;
  logic       ds_rd_i = 1'b0;
  logic       rw_wr_i = 1'b1;
  logic [7:0] ad_i = '0;
  logic [7:0] ad_o;
  logic       ad_oe;
  logic       ram_clr_n = 1'b1;
  logic       tk_valid = 1'b0;
  logic       tk_ready;
  logic       tk_last = 1'b0;
  logic [3:0] tk_idx = '0;
  logic [7:0] tk_data = '0;

  int n_run = 0;
  int n_fail = 0;
  int n_yield = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mbus_regfile u_mbus_regfile (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .as_i(as_i),
    .ds_rd_i(ds_rd_i), .rw_wr_i(rw_wr_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
    .ram_clr_n(ram_clr_n), .tk_valid(tk_valid), .tk_ready(tk_ready),
    .tk_last(tk_last), .tk_idx(tk_idx), .tk_data(tk_data)
  );

  always @(negedge clk) if (rst_n && !tk_ready) n_yield++;

  function automatic logic [7:0] pat_a(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] pat_b(int b);
    return 8'(((b * 91 + 5) & 255) ^ 8'h5A);
  endfunction
  function automatic logic [7:0] pat_c(int a);
    return 8'(((a * 13 + 200) & 255) ^ 8'hA5);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle(logic mode);
    bus_mode = mode;
    ds_rd_i  = mode ? 1'b0 : 1'b1;
    rw_wr_i  = 1'b1;
    tick(3);
  endtask

  task automatic addr_phase(int a, bit sel);
    cs_n = ~sel;
    ad_i = 8'(a);
    as_i = 1'b1;
    tick(2);
    as_i = 1'b0;
    tick(3);
    cs_n = 1'b1;
  endtask

  task automatic bus_write(int a, logic [7:0] d, bit sel);
    addr_phase(a, sel);
    ad_i = d;
    if (bus_mode) begin
      rw_wr_i = 1'b0; tick(1);
      ds_rd_i = 1'b1; tick(2);
      ds_rd_i = 1'b0; tick(3);
      rw_wr_i = 1'b1;
    end else begin
      rw_wr_i = 1'b0; tick(2);
      rw_wr_i = 1'b1; tick(3);
    end
    tick(1);
  endtask

  task automatic bus_read(int a, bit sel, output logic [7:0] d, output logic oe,
                          output logic oe_after);
    addr_phase(a, sel);
    ad_i = '0;
    if (bus_mode) begin rw_wr_i = 1'b1; ds_rd_i = 1'b1; end
    else ds_rd_i = 1'b0;
    tick(3);
    d  = ad_o;
    oe = ad_oe;
    ds_rd_i = bus_mode ? 1'b0 : 1'b1;
    tick(3);
    oe_after = ad_oe;
  endtask

  task automatic read_expect(int a, logic [7:0] exp, string req);
    logic [7:0] d;
    logic oe, oe2;
    bus_read(a, 1'b1, d, oe, oe2);
    check(oe == 1'b1 && d == exp, req, {oe, d}, {1'b1, exp});
    check(oe2 == 1'b0 && ad_o == 8'h00, "R4 idle after read", {oe2, ad_o}, 0);
  endtask

  initial begin
    logic [7:0] d;
    logic oe, oe2;
    int y0;
    tick(4);
    check(ad_oe == 1'b0, "R8 oe in reset", ad_oe, 0);
    rst_n = 1'b1;
    tick(2);
    check(tk_ready == 1'b1, "R9 ready idle", tk_ready, 1);
    go_idle(1'b1);
    read_expect(5, 8'h00, "R8 clock byte reset");
    read_expect(13, 8'h00, "R8 clock byte reset");

    // R2 / R5 / R6: direction-level sweep of main map and bank
    for (int a = 0; a < 128; a++) bus_write(a, pat_a(a), 1'b1);
    for (int b = 0; b < 64; b++) bus_write(128 + b, pat_b(b), 1'b1);
    for (int a = 0; a < 128; a++) read_expect(a, pat_a(a), a < 14 ? "R5 clock R2" : "R5 ram R2");
    for (int b = 0; b < 64; b++) read_expect(128 + b, pat_b(b), "R6 bank R2");

    // R3: split-strobe sweep
    go_idle(1'b0);
    for (int a = 0; a < 128; a++) bus_write(a, pat_c(a), 1'b1);
    for (int b = 0; b < 64; b++) bus_write(128 + b, pat_c(b + 300), 1'b1);
    for (int a = 0; a < 128; a++) read_expect(a, pat_c(a), "R3 main");
    for (int b = 0; b < 64; b++) read_expect(128 + b, pat_c(b + 300), "R3 bank R6");

    // R1: unselected cycles
    bus_write(20, 8'h00, 1'b0);
    bus_write(3, 8'h00, 1'b0);
    bus_read(20, 1'b0, d, oe, oe2);
    check(oe == 1'b0 && d == 8'h00, "R1 unselected read drives", {oe, d}, 0);
    read_expect(20, pat_c(20), "R1 unselected write ram");
    read_expect(3, pat_c(3), "R1 unselected write clock");
    go_idle(1'b1);
    bus_write(40, 8'h00, 1'b0);
    read_expect(40, pat_c(40), "R1 unselected write dir");

    // R7: clear to ones
    ram_clr_n = 1'b0;
    bus_write(50, 8'h12, 1'b1);
    ram_clr_n = 1'b1;
    tick(2);
    for (int a = 0; a < 128; a++) read_expect(a, a < 14 ? pat_c(a) : 8'hFF, "R7 after clear");
    for (int b = 0; b < 64; b++) read_expect(128 + b, 8'hFF, "R7 bank after clear");

    // R9 / R10: timekeeper burst with host read mid-burst
    for (int i = 0; i < 13; i++) begin
      tk_valid = 1'b1; tk_idx = 4'(i); tk_data = 8'(8'hC0 + i); tk_last = 1'b0;
      tick(1);
      check(tk_ready == 1'b1, "R9 ready during burst", tk_ready, 1);
    end
    tk_valid = 1'b0;
    read_expect(2, pat_c(2), "R10 frozen mid-burst");
    read_expect(12, pat_c(12), "R10 frozen mid-burst");
    tk_valid = 1'b1; tk_idx = 4'd13; tk_data = 8'hCD; tk_last = 1'b1;
    tick(1);
    tk_valid = 1'b0; tk_last = 1'b0;
    tick(2);
    read_expect(2, 8'hC2, "R10 new after last");
    read_expect(13, 8'hCD, "R9 beat written");

    // R11 / R9: host write to clock byte and ready yield
    y0 = n_yield;
    bus_write(4, 8'h3C, 1'b1);
    check(n_yield - y0 == 1, "R9 single yield cycle", n_yield - y0, 1);
    read_expect(4, 8'h3C, "R11 host clock write");
    y0 = n_yield;
    bus_write(60, 8'h77, 1'b1);
    check(n_yield == y0, "R9 no yield for ram", n_yield - y0, 0);
    read_expect(60, 8'h77, "R5 ram after clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule